// File: doc/BRIEF.md
# Block Transfer Descriptor Queue

This block holds pending single-block data transfers for a card data engine. Software enters a transfer by writing two words to one of two queue addresses, one for reads from the card (receive) and one for writes to the card (transmit). The first word is the memory buffer address and the second is the card block address. A transfer is queued only when the second word arrives. Every queued descriptor moves exactly one 512-byte block.

The engine takes descriptors over a valid/ready stream. The block offers one descriptor at a time. Receive and transmit descriptors are served in the order they were committed. A descriptor keeps its slot until the engine reports completion with `eng_done`. Two plain status words are always visible. `buf_status` gives the free slot count of each queue. `dat_status` gathers the result flags, and software clears it by writing zero to its address.

Back-pressure rules: once `xfer_valid` rises, it stays high with `xfer_dir`, `xfer_buf` and `xfer_card` unchanged until a cycle in which `xfer_ready` is high. After that handshake, `xfer_valid` stays low until the engine pulses `eng_done`. `eng_done` has no effect while no descriptor is outstanding.

Top module: `blkdesc_queue`

## Requirements
- R1: After reset, `buf_status` reads 0x0808, `dat_status` reads 0 and `xfer_valid` is low.
- R2: A write to a queue address commits a descriptor only if it is the second write to that same address. A lone first write, or a write to any other address, leaves `buf_status` and `xfer_valid` unchanged. The receive and transmit addresses each keep their own pending first word.
- R3: The receive queue address is 0x60 and the transmit queue address is 0x80. The first word of a pair is presented on `xfer_buf` and the second on `xfer_card`. `xfer_dir` is 1 for transmit and 0 for receive.
- R4: `buf_status[7:0]` is the number of free transmit slots, `buf_status[15:8]` is the number of free receive slots, and bits [31:16] are zero. Each queue has 8 slots.
- R5: If the second write arrives while its queue is full, the descriptor is dropped. The free count stays at 0 and never goes below it.
- R6: Descriptors from both queues are offered one at a time, in the order their second writes arrived.
- R7: `xfer_valid` obeys the back-pressure rules above. A descriptor's slot is released, and its free count goes up, on the clock edge that samples `eng_done`. The new count is visible after that edge.
- R8: A completion with `eng_err` = 0 sets `dat_status` bit 0.
- R9: A completion with `eng_err` nonzero sets `dat_status` bits from the error code. `eng_err[0]` (retry) sets bit 1, `eng_err[1]` (FIFO) sets bit 2, `eng_err[2]` (command) sets bit 4, and `eng_err[3]` (transmission) sets bit 5.
- R10: `dat_status` bits stay set until software writes zero to address 0x54. A nonzero write to that address is ignored. If a completion arrives in the same cycle as the clearing write, the completion's flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| buf_status | output | 32 | Free slot counts: transmit in [7:0], receive in [15:8] |
| dat_status | output | 32 | Sticky completion and error flags |
| xfer_valid | output | 1 | A descriptor is offered to the engine |
| xfer_ready | input | 1 | The engine accepts the offered descriptor |
| xfer_dir | output | 1 | 1 = transmit, 0 = receive |
| xfer_buf | output | 32 | Memory buffer address of the offered descriptor |
| xfer_card | output | 32 | Card block address of the offered descriptor |
| eng_done | input | 1 | One-cycle pulse: the outstanding descriptor has finished |
| eng_err | input | 4 | Error code sampled together with `eng_done` |

## Verification
A committing write shows up in `buf_status` and `xfer_valid` after the same clock edge that samples it. A completion changes `dat_status` and the free counts one edge after `eng_done` is driven. Inputs are driven on the falling edge, so the bench reads results at the next falling edge. A scoreboard fed by the driver holds each expected descriptor. A monitor pulls descriptors off the stream at the falling edge, compares them in order, answers after a fixed latency, and records the expected flags once its done pulse has been sampled. The bench changes `xfer_ready` just after a rising edge, so the monitor and the design always see the same value.

// File: rtl/bdq_pkg.sv
package bdq_pkg;
  localparam int WORD_W = 32;
  localparam int ERR_W  = 4;
  localparam int FLAG_W = 6;

  typedef struct packed {
    logic [WORD_W-1:0] bufa;
    logic [WORD_W-1:0] card;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/bdq_fifo.sv
module bdq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bdq_port.sv
module bdq_port
  import bdq_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  PORT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              full,
  output logic              commit,
  output desc_t             desc
);
  logic              hit;
  logic              pend;
  logic [WORD_W-1:0] held_buf;

  assign hit       = wr_en && (wr_addr == PORT_ADDR);
  assign commit    = hit && pend && !full;
  assign desc.bufa = held_buf;
  assign desc.card = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      held_buf <= '0;
    end else if (hit) begin
      if (!pend) begin
        held_buf <= wr_data;
        pend     <= 1'b1;
      end else begin
        pend     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdq_status.sv
module bdq_status
  import bdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic [ERR_W-1:0] err,
  input  logic             clr,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] add_bits;
  logic [FLAG_W-1:0] base;

  always_comb begin
    if (err == '0) add_bits = FLAG_W'(1);
    else           add_bits = {err[3], err[2], 1'b0, err[1], err[0], 1'b0};
    base = clr ? '0 : flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flags <= '0;
    else if (finish) flags <= base | add_bits;
    else             flags <= base;
  end
endmodule

// File: rtl/blkdesc_queue.sv
module blkdesc_queue
  import bdq_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DEPTH      = 8,
  parameter logic [ADDR_W-1:0] RX_ADDR    = 8'h60,
  parameter logic [ADDR_W-1:0] TX_ADDR    = 8'h80,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       buf_status,
  output logic [31:0]       dat_status,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic              xfer_dir,
  output logic [31:0]       xfer_buf,
  output logic [31:0]       xfer_card,
  input  logic              eng_done,
  input  logic [3:0]        eng_err
);
  localparam int CNT_W   = $clog2(DEPTH+1);
  localparam int ORD_D   = 2 * DEPTH;
  localparam int ORD_C_W = $clog2(ORD_D+1);
  localparam int NQ      = 2;

  logic [NQ-1:0]     commit;
  logic [NQ-1:0]     q_full;
  logic [NQ-1:0]     q_pop;
  desc_t             c_desc [NQ];
  logic [DESC_W-1:0] q_head [NQ];
  logic [CNT_W-1:0]  q_cnt  [NQ];
  logic [7:0]        q_free [NQ];

  logic                busy;
  logic                finish;
  logic                cur_dir;
  logic                ord_empty;
  logic                ord_full;
  logic [0:0]          ord_head;
  logic [ORD_C_W-1:0]  ord_cnt;
  logic                clr;
  logic [FLAG_W-1:0]   flags;
  desc_t               head;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam logic [ADDR_W-1:0] PA = (g == 1) ? TX_ADDR : RX_ADDR;
    logic q_empty;

    bdq_port #(.ADDR_W(ADDR_W), .PORT_ADDR(PA)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .full    (q_full[g]),
      .commit  (commit[g]),
      .desc    (c_desc[g])
    );

    assign q_pop[g] = finish && (cur_dir == 1'(g));

    bdq_fifo #(.W(DESC_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (commit[g]),
      .din   (c_desc[g]),
      .pop   (q_pop[g]),
      .dout  (q_head[g]),
      .count (q_cnt[g]),
      .full  (q_full[g]),
      .empty (q_empty)
    );

    assign q_free[g] = 8'(DEPTH) - 8'(q_cnt[g]);
  end

  bdq_fifo #(.W(1), .DEPTH(ORD_D)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (|commit),
    .din   (commit[1]),
    .pop   (finish),
    .dout  (ord_head),
    .count (ord_cnt),
    .full  (ord_full),
    .empty (ord_empty)
  );

  assign cur_dir    = ord_head[0];
  assign head       = desc_t'(cur_dir ? q_head[1] : q_head[0]);
  assign xfer_valid = !busy && !ord_empty;
  assign xfer_dir   = cur_dir;
  assign xfer_buf   = head.bufa;
  assign xfer_card  = head.card;
  assign finish     = busy && eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n)                       busy <= 1'b0;
    else if (xfer_valid && xfer_ready) busy <= 1'b1;
    else if (finish)                  busy <= 1'b0;
  end

  assign clr = wr_en && (wr_addr == DSTAT_ADDR) && (wr_data == '0);

  bdq_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .finish (finish),
    .err    (eng_err),
    .clr    (clr),
    .flags  (flags)
  );

  assign buf_status = {16'h0, q_free[0], q_free[1]};
  assign dat_status = {{(32-FLAG_W){1'b0}}, flags};
endmodule

// File: rtl/bdq_checker.sv
module bdq_checker #(
  parameter int          DEPTH      = 8,
  parameter logic [7:0]  DSTAT_ADDR = 8'h54
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [31:0] buf_status,
  input logic [31:0] dat_status,
  input logic        xfer_valid,
  input logic        xfer_ready,
  input logic        xfer_dir,
  input logic [31:0] xfer_buf,
  input logic [31:0] xfer_card,
  input logic        eng_done,
  input logic [3:0]  eng_err,
  input logic        busy
);
  assert_free_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_status[7:0] <= 8'(DEPTH)) && (buf_status[15:8] <= 8'(DEPTH)));

  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_dir)
      && $stable(xfer_buf) && $stable(xfer_card)));

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> !xfer_valid);

  assert_quiet_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(busy && eng_done)) |=> $stable(buf_status));

  assert_success_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_err == 4'd0) |=> dat_status[0]);

  assert_cmd_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_err[2]) |=> dat_status[4]);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == DSTAT_ADDR && wr_data == 32'd0 && !(busy && eng_done))
      |=> (dat_status == 32'd0));

  assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_status[15:0] == {8'(DEPTH), 8'(DEPTH)}) |-> !xfer_valid);
endmodule

bind blkdesc_queue bdq_checker #(.DEPTH(DEPTH), .DSTAT_ADDR(DSTAT_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .buf_status (buf_status),
  .dat_status (dat_status),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_dir   (xfer_dir),
  .xfer_buf   (xfer_buf),
  .xfer_card  (xfer_card),
  .eng_done   (eng_done),
  .eng_err    (eng_err),
  .busy       (busy)
);

// File: tb/blkdesc_queue_test.sv
module blkdesc_queue_test;
  localparam logic [7:0] RXA = 8'h60;
  localparam logic [7:0] TXA = 8'h80;
  localparam logic [7:0] STA = 8'h54;

  typedef struct {
    logic        dir;
    logic [31:0] bufa;
    logic [31:0] card;
    logic [3:0]  err;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] buf_status, dat_status;
  logic        xfer_valid, xfer_dir;
  logic        xfer_ready = 0;
  logic [31:0] xfer_buf, xfer_card;
  logic        eng_done = 0;
  logic [3:0]  eng_err = 0;

  item_t       sb[$];
  int          total = 0;
  int          bad = 0;
  int          ncomp = 0;
  logic [31:0] exp_stat = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  blkdesc_queue uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_status(buf_status), .dat_status(dat_status), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_dir(xfer_dir), .xfer_buf(xfer_buf),
    .xfer_card(xfer_card), .eng_done(eng_done), .eng_err(eng_err)
  );

  function automatic logic [31:0] flag_of(input logic [3:0] e);
    if (e == 4'd0) return 32'h1;
    return {26'd0, e[3], e[2], 1'b0, e[1], e[0], 1'b0};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push_desc(input logic dir, input logic [31:0] b, input logic [31:0] c,
                           input logic [3:0] e, input bit accepted);
    item_t it;
    wr(dir ? TXA : RXA, b);
    wr(dir ? TXA : RXA, c);
    if (accepted) begin
      it.dir = dir; it.bufa = b; it.card = c; it.err = e;
      sb.push_back(it);
    end
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 xfer_ready = v;
  endtask

  task automatic wait_comp(input int n);
    while (ncomp < n) @(negedge clk);
    @(negedge clk);
  endtask

  // Engine model and monitor
  initial begin
    item_t it;
    @(negedge clk);
    forever begin
      if (rst_n && xfer_valid && xfer_ready) begin
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R5: actual=unexpected descriptor %h expected=none", xfer_card);
          @(negedge clk);
        end else begin
          it = sb.pop_front();
          chk({31'd0, xfer_dir}, {31'd0, it.dir}, "R6 direction order");
          chk(xfer_buf, it.bufa, "R3 buffer word");
          chk(xfer_card, it.card, "R3 card word");
          repeat (3) @(negedge clk);
          eng_err = it.err; eng_done = 1;
          @(negedge clk);
          eng_done = 0; eng_err = 0;
          exp_stat = exp_stat | flag_of(it.err);
          ncomp++;
        end
      end else begin
        @(negedge clk);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(buf_status, 32'h0808, "R1 free counts");
    chk(dat_status, 32'h0, "R1 data status");
    chk({31'd0, xfer_valid}, 32'h0, "R1 valid low");

    // R2 lone first write and foreign address
    wr(TXA, 32'hAAAA_0001);
    chk(buf_status, 32'h0808, "R2 lone first write");
    chk({31'd0, xfer_valid}, 32'h0, "R2 no offer");
    wr(8'h40, 32'h1234);
    chk(buf_status, 32'h0808, "R2 other address");
    // receive pair interleaved before transmit partner
    push_desc(1'b0, 32'hB000_0010, 32'h0000_0200, 4'd0, 1'b1);
    chk(buf_status, 32'h0708, "R4 rx byte");
    wr(TXA, 32'h0000_0400);
    begin
      item_t it;
      it.dir = 1; it.bufa = 32'hAAAA_0001; it.card = 32'h0000_0400; it.err = 4'd0;
      sb.push_back(it);
    end
    chk(buf_status, 32'h0707, "R4 both bytes");
    chk({31'd0, xfer_valid}, 32'h1, "R7 offer");
    chk({31'd0, xfer_dir}, 32'h0, "R6 first committed first");
    repeat (3) @(negedge clk);
    chk({31'd0, xfer_valid}, 32'h1, "R7 hold valid");
    chk(xfer_buf, 32'hB000_0010, "R7 hold data");
    chk(buf_status, 32'h0707, "R7 slot kept");
    set_ready(1);
    wait_comp(2);
    chk(buf_status, 32'h0808, "R7 slots released");
    chk(dat_status, exp_stat, "R8 success flag");
    chk(dat_status, 32'h1, "R8 bit0");

    // R10 clear behaviour
    wr(STA, 32'h5);
    chk(dat_status, 32'h1, "R10 nonzero write ignored");
    wr(STA, 32'h0);
    exp_stat = 0;
    chk(dat_status, 32'h0, "R10 zero clears");

    // R9 error codes, mixed order
    set_ready(0);
    push_desc(1'b1, 32'hC000_0000, 32'h10, 4'b0001, 1'b1);
    push_desc(1'b0, 32'hC000_1000, 32'h20, 4'b1000, 1'b1);
    push_desc(1'b1, 32'hC000_2000, 32'h30, 4'b0110, 1'b1);
    chk(buf_status, 32'h0706, "R4 mixed counts");
    set_ready(1);
    wait_comp(5);
    chk(dat_status, 32'h36, "R9 error flags");
    chk(dat_status, exp_stat, "R9 scoreboard flags");
    wr(STA, 32'h0);
    exp_stat = 0;

    // R5 full receive queue
    set_ready(0);
    for (int i = 0; i < 8; i++)
      push_desc(1'b0, 32'hD000_0000 + 32'(i), 32'(i) * 32'd512, 4'd0, 1'b1);
    chk(buf_status, 32'h0008, "R5 rx full");
    push_desc(1'b0, 32'hDEAD_0000, 32'hFFFF, 4'd0, 1'b0);
    chk(buf_status, 32'h0008, "R5 dropped when full");
    push_desc(1'b1, 32'hE000_0000, 32'h40, 4'd0, 1'b1);
    chk(buf_status, 32'h0007, "R5 tx still accepted");
    set_ready(1);
    wait_comp(14);
    repeat (5) @(negedge clk);
    chk(buf_status, 32'h0808, "R5 drained");
    chk(dat_status, 32'h1, "R8 success after drain");
    chk(32'(sb.size()), 32'd0, "R6 scoreboard empty");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule